// File: doc/BRIEF.md
# IO Request/Response Queue Bridge

This block sits between a multithreaded load/store unit and the path that carries memory-mapped IO operations. Each IO operation the load/store unit offers is stored in a request queue. It stays there, presented on a downstream issue port, until a completion comes back for it. When the completion is accepted, the head request leaves the request queue. In the same clock edge, a response made of the requesting thread and the returned data enters a separate response queue.

The load/store unit reads the response queue at its own pace. It sees a valid flag, the thread to wake and the data of the oldest response. It retires that response with a one-cycle consume pulse. Flow control is local to the bridge. The upstream side sees an available flag that drops when the request queue is full. The downstream side sees a completion-ready flag that drops when a completion cannot be taken.

Top module: `io_queue_bridge`

## Requirements
- R1: Reset (active-low, asynchronous) empties both queues: `req_avail_o` is high, and `iss_valid_o`, `rsp_valid_o` and `cpl_ready_o` are low.
- R2: Each queue holds DEPTH entries (default 8). A request is stored at a clock edge where `req_valid_i` and `req_avail_o` are both high. `req_avail_o` is low exactly when DEPTH requests are held. A request offered while the queue is full is dropped and never issued.
- R3: The issue port presents the oldest stored request: `iss_valid_o` is high when the request queue is non-empty, and thread, operation, address and data come from its head. Requests are issued in arrival order. An entry is packed as {thread, operation, address, data}, most significant field first.
- R4: `cpl_ready_o` is high exactly when the request queue is non-empty and the response queue is not full. At an edge where `cpl_valid_i` and `cpl_ready_o` are both high, the head request is removed and a response is appended. That response carries the thread of the removed request and `cpl_data_i`.
- R5: A completion offered while `cpl_ready_o` is low has no effect: the head request stays on the issue port unchanged, and the response queue is unchanged.
- R6: The response port presents the oldest response: `rsp_valid_o` is high when the response queue is non-empty, and `rsp_thread_o` and `rsp_data_o` come from its head. A one-cycle `rsp_consume_i` pulse removes exactly one response. A consume pulse while the queue is empty is ignored.
- R7: On either queue, an append and a removal at the same edge leave the occupancy unchanged and keep the order.
- R8: Every effect of an input becomes visible on the outputs right after the clock edge that samples it. No extra cycles of latency are added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | IO request offered by the load/store unit |
| req_thread_i | input | THREAD_W | Requesting thread |
| req_op_i | input | OP_W | IO operation code |
| req_addr_i | input | ADDR_W | IO address |
| req_data_i | input | DATA_W | Write data word |
| req_avail_o | output | 1 | Request queue can take a request |
| iss_valid_o | output | 1 | A request is waiting for completion |
| iss_thread_o | output | THREAD_W | Head request thread |
| iss_op_o | output | OP_W | Head request operation |
| iss_addr_o | output | ADDR_W | Head request address |
| iss_data_o | output | DATA_W | Head request data |
| cpl_valid_i | input | 1 | Completion for the head request |
| cpl_data_i | input | DATA_W | Completion data |
| cpl_ready_o | output | 1 | Completion will be accepted this cycle |
| rsp_valid_o | output | 1 | A response is waiting |
| rsp_thread_o | output | THREAD_W | Thread to wake |
| rsp_data_o | output | DATA_W | Response data |
| rsp_consume_i | input | 1 | One-cycle pulse retiring the head response |

## Verification
Every result is due one clock edge after its stimulus. Queue state updates at that edge, and all outputs are decoded from the queue heads and counts without further registers. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. The one exception is `cpl_ready_o`, which depends only on queue state. It is sampled in the half cycle before the edge that would consume the completion. This confirms the back-pressure before the stimulus can act.

// File: rtl/io_bridge_pkg.sv
package io_bridge_pkg;
  localparam int unsigned IOB_DEPTH    = 8;
  localparam int unsigned IOB_THREAD_W = 2;
  localparam int unsigned IOB_OP_W     = 2;
  localparam int unsigned IOB_ADDR_W   = 32;
  localparam int unsigned IOB_DATA_W   = 32;

  function automatic int unsigned iob_cnt_w(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/iob_fifo.sv
module iob_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = io_bridge_pkg::iob_cnt_w(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  // storage needs no reset
  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end
endmodule

// File: rtl/iob_xfer_ctl.sv
module iob_xfer_ctl (
  input  logic req_valid_i,
  input  logic req_full_i,
  input  logic req_empty_i,
  input  logic cpl_valid_i,
  input  logic rsp_full_i,
  input  logic rsp_empty_i,
  input  logic consume_i,
  output logic req_push_o,
  output logic xfer_o,
  output logic rsp_pop_o,
  output logic req_avail_o,
  output logic cpl_ready_o
);
  assign req_avail_o = !req_full_i;
  assign req_push_o  = req_valid_i && !req_full_i;
  assign cpl_ready_o = !req_empty_i && !rsp_full_i;
  // completion pops request and pushes response in one edge
  assign xfer_o      = cpl_valid_i && cpl_ready_o;
  assign rsp_pop_o   = consume_i && !rsp_empty_i;
endmodule

// File: rtl/io_queue_bridge.sv
module io_queue_bridge #(
  parameter int unsigned DEPTH    = io_bridge_pkg::IOB_DEPTH,
  parameter int unsigned THREAD_W = io_bridge_pkg::IOB_THREAD_W,
  parameter int unsigned OP_W     = io_bridge_pkg::IOB_OP_W,
  parameter int unsigned ADDR_W   = io_bridge_pkg::IOB_ADDR_W,
  parameter int unsigned DATA_W   = io_bridge_pkg::IOB_DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [THREAD_W-1:0] req_thread_i,
  input  logic [OP_W-1:0]     req_op_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_data_i,
  output logic                req_avail_o,
  output logic                iss_valid_o,
  output logic [THREAD_W-1:0] iss_thread_o,
  output logic [OP_W-1:0]     iss_op_o,
  output logic [ADDR_W-1:0]   iss_addr_o,
  output logic [DATA_W-1:0]   iss_data_o,
  input  logic                cpl_valid_i,
  input  logic [DATA_W-1:0]   cpl_data_i,
  output logic                cpl_ready_o,
  output logic                rsp_valid_o,
  output logic [THREAD_W-1:0] rsp_thread_o,
  output logic [DATA_W-1:0]   rsp_data_o,
  input  logic                rsp_consume_i
);
  localparam int unsigned REQ_W = THREAD_W + OP_W + ADDR_W + DATA_W;
  localparam int unsigned RSP_W = THREAD_W + DATA_W;

  logic [REQ_W-1:0] req_wdata, req_head;
  logic [RSP_W-1:0] rsp_wdata, rsp_head;
  logic req_empty, req_full, rsp_empty, rsp_full;
  logic req_push, xfer, rsp_pop;

  iob_xfer_ctl u_ctl (
    .req_valid_i (req_valid_i),
    .req_full_i  (req_full),
    .req_empty_i (req_empty),
    .cpl_valid_i (cpl_valid_i),
    .rsp_full_i  (rsp_full),
    .rsp_empty_i (rsp_empty),
    .consume_i   (rsp_consume_i),
    .req_push_o  (req_push),
    .xfer_o      (xfer),
    .rsp_pop_o   (rsp_pop),
    .req_avail_o (req_avail_o),
    .cpl_ready_o (cpl_ready_o)
  );

  assign req_wdata = {req_thread_i, req_op_i, req_addr_i, req_data_i};

  iob_fifo #(.WIDTH(REQ_W), .DEPTH(DEPTH)) u_req_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (req_push),
    .wdata_i (req_wdata),
    .pop_i   (xfer),
    .rdata_o (req_head),
    .empty_o (req_empty),
    .full_o  (req_full)
  );

  assign {iss_thread_o, iss_op_o, iss_addr_o, iss_data_o} = req_head;
  assign iss_valid_o = !req_empty;

  assign rsp_wdata = {iss_thread_o, cpl_data_i};

  iob_fifo #(.WIDTH(RSP_W), .DEPTH(DEPTH)) u_rsp_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (xfer),
    .wdata_i (rsp_wdata),
    .pop_i   (rsp_pop),
    .rdata_o (rsp_head),
    .empty_o (rsp_empty),
    .full_o  (rsp_full)
  );

  assign {rsp_thread_o, rsp_data_o} = rsp_head;
  assign rsp_valid_o = !rsp_empty;
endmodule

// File: rtl/io_queue_bridge_chk.sv
module io_queue_bridge_chk #(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned THREAD_W = 2,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_avail_o,
  input logic                iss_valid_o,
  input logic [THREAD_W-1:0] iss_thread_o,
  input logic [ADDR_W-1:0]   iss_addr_o,
  input logic                cpl_valid_i,
  input logic                cpl_ready_o,
  input logic                rsp_valid_o,
  input logic [THREAD_W-1:0] rsp_thread_o,
  input logic [DATA_W-1:0]   rsp_data_o,
  input logic                rsp_consume_i
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  // occupancy seen from the port handshakes
  logic [CNT_W-1:0] occ_q;
  logic acc_in, acc_out;
  assign acc_in  = req_valid_i && req_avail_o;
  assign acc_out = cpl_valid_i && cpl_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else if (acc_in && !acc_out) occ_q <= occ_q + 1'b1;
    else if (acc_out && !acc_in) occ_q <= occ_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_EMPTY: assert (!iss_valid_o && !rsp_valid_o && req_avail_o); // R1
  end

  AST_AVAIL_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_avail_o == (occ_q != CNT_W'(DEPTH))); // R2
  AST_ISS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o == (occ_q != '0)); // R3
  AST_CPL_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_ready_o |-> iss_valid_o); // R4
  AST_CPL_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_i && cpl_ready_o) |=> rsp_valid_o); // R4
  AST_ISS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && !(cpl_valid_i && cpl_ready_o)) |=>
      (iss_valid_o && $stable(iss_addr_o) && $stable(iss_thread_o))); // R5
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_consume_i) |=>
      (rsp_valid_o && $stable(rsp_thread_o) && $stable(rsp_data_o))); // R6
endmodule

bind io_queue_bridge io_queue_bridge_chk #(
  .DEPTH(DEPTH), .THREAD_W(THREAD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_avail_o  (req_avail_o),
  .iss_valid_o  (iss_valid_o),
  .iss_thread_o (iss_thread_o),
  .iss_addr_o   (iss_addr_o),
  .cpl_valid_i  (cpl_valid_i),
  .cpl_ready_o  (cpl_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_thread_o (rsp_thread_o),
  .rsp_data_o   (rsp_data_o),
  .rsp_consume_i(rsp_consume_i)
);

// File: tb/io_queue_bridge_test.sv
`timescale 1ns/1ps
module io_queue_bridge_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_thread = '0;
  logic [1:0]  req_op = '0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic        cpl_valid = 1'b0;
  logic [31:0] cpl_data = '0;
  logic        consume = 1'b0;
  logic        req_avail, iss_valid, cpl_ready, rsp_valid;
  logic [1:0]  iss_thread, iss_op, rsp_thread;
  logic [31:0] iss_addr, iss_data, rsp_data;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  io_queue_bridge uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_thread_i(req_thread), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_data_i(req_data), .req_avail_o(req_avail),
    .iss_valid_o(iss_valid), .iss_thread_o(iss_thread), .iss_op_o(iss_op),
    .iss_addr_o(iss_addr), .iss_data_o(iss_data),
    .cpl_valid_i(cpl_valid), .cpl_data_i(cpl_data), .cpl_ready_o(cpl_ready),
    .rsp_valid_o(rsp_valid), .rsp_thread_o(rsp_thread), .rsp_data_o(rsp_data),
    .rsp_consume_i(consume)
  );

  typedef struct packed {
    logic rv; logic [7:0] ra;
    logic cv; logic [7:0] cd;
    logic cs;
    logic eav; logic eiv; logic [7:0] eia;
    logic erv; logic [7:0] erd;
  } vec_t;

  // state after one edge; thread = ra[1:0], op = ra[3:2], data = ~ra
  localparam vec_t TBL [8] = '{
    '{1'b1, 8'h10, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h10, 1'b0, 8'h00},
    '{1'b1, 8'h21, 1'b1, 8'hA0, 1'b0, 1'b1, 1'b1, 8'h21, 1'b1, 8'hA0},
    '{1'b1, 8'h32, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h21, 1'b1, 8'hA0},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h21, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b1, 8'hB1, 1'b1, 1'b1, 1'b1, 8'h32, 1'b1, 8'hB1},
    '{1'b0, 8'h00, 1'b1, 8'hC2, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 8'hC2},
    '{1'b0, 8'h00, 1'b1, 8'hD3, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 8'hC2},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; cpl_valid = 1'b0; consume = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put_req(input logic [1:0] th, input logic [1:0] op,
                         input logic [31:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_thread = th; req_op = op; req_addr = a; req_data = d;
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "avail", 32'(req_avail), 32'd1);
    chk("R1", "iss_valid", 32'(iss_valid), 32'd0);
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1", "cpl_ready", 32'(cpl_ready), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // table walk: R3 R4 R6 R7 R8
    foreach (TBL[i]) begin
      req_valid = TBL[i].rv;
      req_thread = TBL[i].ra[1:0];
      req_op = TBL[i].ra[3:2];
      req_addr = {24'h0, TBL[i].ra};
      req_data = {24'h0, ~TBL[i].ra};
      cpl_valid = TBL[i].cv;
      cpl_data = {24'h0, TBL[i].cd};
      consume = TBL[i].cs;
      step();
      chk("R8", $sformatf("row%0d avail", i), 32'(req_avail), 32'(TBL[i].eav));
      chk("R3", $sformatf("row%0d iss_valid", i), 32'(iss_valid), 32'(TBL[i].eiv));
      if (TBL[i].eiv) chk("R7", $sformatf("row%0d iss_addr", i), iss_addr, {24'h0, TBL[i].eia});
      chk("R6", $sformatf("row%0d rsp_valid", i), 32'(rsp_valid), 32'(TBL[i].erv));
      if (TBL[i].erv) chk("R4", $sformatf("row%0d rsp_data", i), rsp_data, {24'h0, TBL[i].erd});
    end
    idle();

    // fill the request queue
    for (int i = 0; i < 8; i++) begin
      put_req(2'(i), 2'(i + 1), 32'h100 + 32'(i), 32'hD000 + 32'(i));
      step();
      if (i == 0) begin
        chk("R3", "iss_thread", 32'(iss_thread), 32'd0);
        chk("R3", "iss_op", 32'(iss_op), 32'd1);
        chk("R3", "iss_data", iss_data, 32'hD000);
      end
    end
    chk("R2", "avail when full", 32'(req_avail), 32'd0);
    put_req(2'd3, 2'd3, 32'h999, 32'h999);
    step();
    idle();
    chk("R2", "avail after refused", 32'(req_avail), 32'd0);
    chk("R2", "head after refused", iss_addr, 32'h100);

    // complete all eight; order proves refused one absent
    for (int i = 0; i < 8; i++) begin
      chk("R3", $sformatf("issue order %0d", i), iss_addr, 32'h100 + 32'(i));
      chk("R4", $sformatf("cpl_ready %0d", i), 32'(cpl_ready), 32'd1);
      cpl_valid = 1'b1; cpl_data = 32'hC0 + 32'(i);
      step();
    end
    idle();
    chk("R2", "refused not issued", 32'(iss_valid), 32'd0);
    chk("R2", "avail after drain", 32'(req_avail), 32'd1);

    // response queue full: back-pressure
    put_req(2'd3, 2'd2, 32'h200, 32'h2222);
    step();
    idle();
    cpl_valid = 1'b1; cpl_data = 32'hFF;
    #0.5;
    chk("R4", "cpl_ready with rsp full", 32'(cpl_ready), 32'd0);
    step();
    idle();
    chk("R5", "head kept", iss_addr, 32'h200);
    chk("R5", "head valid", 32'(iss_valid), 32'd1);
    chk("R5", "rsp head unchanged", rsp_data, 32'hC0);

    // drain responses in order
    for (int i = 0; i < 8; i++) begin
      chk("R6", $sformatf("rsp_valid %0d", i), 32'(rsp_valid), 32'd1);
      chk("R4", $sformatf("rsp_thread %0d", i), 32'(rsp_thread), 32'(i % 4));
      chk("R6", $sformatf("rsp_data %0d", i), rsp_data, 32'hC0 + 32'(i));
      consume = 1'b1;
      step();
      consume = 1'b0;
    end
    chk("R6", "rsp empty", 32'(rsp_valid), 32'd0);

    // simultaneous push and pop on request queue
    put_req(2'd1, 2'd0, 32'h300, 32'h3333);
    cpl_valid = 1'b1; cpl_data = 32'hEE;
    step();
    idle();
    chk("R7", "new head", iss_addr, 32'h300);
    chk("R7", "avail", 32'(req_avail), 32'd1);
    chk("R4", "moved thread", 32'(rsp_thread), 32'd3);
    chk("R4", "moved data", rsp_data, 32'hEE);

    // reset while busy
    rst_ni = 1'b0;
    #1;
    chk("R1", "iss after reset", 32'(iss_valid), 32'd0);
    chk("R1", "rsp after reset", 32'(rsp_valid), 32'd0);
    chk("R1", "avail after reset", 32'(req_avail), 32'd1);
    @(negedge clk);
    rst_ni = 1'b1;
    step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule